// File: doc/BRIEF.md
# Vector Register Load Decoder and Address Generator

This block serves one load form: it moves 8, 16, 32, 64 or 128 bits from memory into a vector register, at a byte address formed from a base register plus a signed 9-bit unscaled offset. It takes one 32-bit instruction word at a time. It checks that the word belongs to this load class and picks the transfer width from the size and opcode fields. It reads the base from a general register or from the stack pointer. It then issues one read request, which carries the width, privilege, tag-check and non-temporal attributes.

Any of three conditions stops the access before a request goes out. They are checked in this priority order: an undefined encoding, floating-point/vector access being disabled, and a misaligned stack-pointer base while the alignment check is enabled. Each raises its own flag for one cycle. On a normal load, the response data is zero-extended to 128 bits and written to the destination vector register in the same cycle the response arrives. Only one load is in flight at a time.

Top module: `vload_unit`

## Requirements
- R1: An instruction is accepted (insn_valid_i and insn_ready_o high at a clock edge) as a load of this class only if bits 29:27 = 111, bit 26 = 1, bits 25:24 = 00, bit 21 = 0, bits 11:10 = 00 and bit 22 = 1. Any other word raises undef_o for one cycle after acceptance and issues no request.
- R2: The width follows size = bits 31:30 and opc = bits 23:22. The pairs 00/01, 01/01, 10/01, 11/01 and 00/11 give req_size_o = 0, 1, 2, 3 and 4, which is log2 of the byte count (1, 2, 4, 8 and 16 bytes).
- R3: When opc bit 1 is 1 and size is not 00, undef_o is raised and no request is issued.
- R4: req_addr_o equals the base plus the 9-bit immediate in bits 20:12, sign-extended, as a byte offset (-256..+255) with no scaling.
- R5: gpr_idx_o always shows bits 9:5 (Rn). Rn = 31 takes the base from sp_i; any other value takes it from gpr_data_i.
- R6: req_tag_chk_o is 1 exactly when Rn is not 31. req_nontemp_o is always 0.
- R7: req_priv_o is 1 when el_i, the 2-bit exception level, is nonzero.
- R8: An encoding that is otherwise valid but arrives with fp_en_i low raises fp_trap_o and issues no request. undef_o takes priority over fp_trap_o, and at most one fault flag is high in any cycle.
- R9: When sp_align_chk_i is high, Rn = 31 and sp_i[3:0] is nonzero, align_fault_o is raised instead of a request. fp_trap_o takes priority over align_fault_o. Misalignment has no effect when the check is off or when Rn is not 31.
- R10: In the state that waits for the response, rsp_valid_i drives vrf_we_o high in the same cycle. vrf_idx_o = Rt (bits 4:0), and vrf_data_o keeps the low 2^req_size bytes of rsp_data_i and zeroes the rest.
- R11: A request appears in the cycle after acceptance and is held with stable fields until req_ready_i. insn_ready_o stays low from acceptance until the write-back cycle has passed.
- R12: After reset, insn_ready_o is 1 and req_valid_o, vrf_we_o and all fault flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | Instruction word valid |
| insn_i | input | 32 | Instruction word |
| insn_ready_o | output | 1 | Block idle, can accept an instruction |
| fp_en_i | input | 1 | FP/vector access enabled |
| el_i | input | 2 | Current exception level |
| sp_align_chk_i | input | 1 | Stack-pointer alignment check enable |
| gpr_idx_o | output | 5 | General register read index |
| gpr_data_i | input | 64 | General register read data |
| sp_i | input | 64 | Stack pointer value |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | 64 | Byte address |
| req_size_o | output | 3 | log2 of the byte count |
| req_priv_o | output | 1 | Privileged access |
| req_tag_chk_o | output | 1 | Tag check required |
| req_nontemp_o | output | 1 | Non-temporal hint |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | 128 | Read response data |
| vrf_we_o | output | 1 | Vector register write enable |
| vrf_idx_o | output | 5 | Vector register index |
| vrf_data_o | output | 128 | Vector register write data |
| undef_o | output | 1 | Undefined-encoding pulse |
| fp_trap_o | output | 1 | FP-disabled trap pulse |
| align_fault_o | output | 1 | Stack-pointer alignment fault pulse |

## Verification
The assertions assume the memory side obeys the handshake. It raises rsp_valid_i only after it has taken a request, and it does not withdraw req_ready_i in a way that drops a request. They also assume insn_valid_i is high in any cycle where an accept can start a request. The bench holds to this: it drives all inputs on the falling edge, gives each instruction exactly one response, and raises it only after the request handshake has completed. gpr_data_i is modelled as a value derived from gpr_idx_o, so the base is known for every register index.

// File: rtl/vload_pkg.sv
package vload_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;

  typedef struct packed {
    logic [2:0] scale;
    logic [4:0] rn;
    logic [4:0] rt;
    logic [8:0] imm;
    logic       undef;
  } dec_t;
endpackage

// File: rtl/vload_decode.sv
module vload_decode
  import vload_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  logic       class_ok;
  logic [1:0] size;
  logic [1:0] opc;

  assign size = insn_i[31:30];
  assign opc  = insn_i[23:22];

  // fixed bits plus load direction (opc[0])
  assign class_ok = (insn_i[29:27] == 3'b111) && insn_i[26] && (insn_i[25:24] == 2'b00)
                 && !insn_i[21] && (insn_i[11:10] == 2'b00) && opc[0];

  always_comb begin
    dec_o.rn    = insn_i[9:5];
    dec_o.rt    = insn_i[4:0];
    dec_o.imm   = insn_i[20:12];
    dec_o.scale = opc[1] ? 3'd4 : {1'b0, size};
    dec_o.undef = !class_ok || (opc[1] && (size != 2'b00));
  end
endmodule

// File: rtl/vload_agu.sv
module vload_agu #(
  parameter int ADDR_W    = 64,
  parameter int IMM_W     = 9,
  parameter int IDX_W     = 5,
  parameter int ALIGN_LSB = 4
) (
  input  logic [IDX_W-1:0]  rn_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] gpr_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              chk_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tag_chk_o,
  output logic              misalign_o
);
  localparam logic [IDX_W-1:0] SP_IDX = {IDX_W{1'b1}};

  logic              use_sp;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;

  assign use_sp     = (rn_i == SP_IDX);
  assign base       = use_sp ? sp_i : gpr_i;
  assign offs       = {{(ADDR_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign addr_o     = base + offs;
  assign tag_chk_o  = !use_sp;
  assign misalign_o = use_sp && chk_en_i && (sp_i[ALIGN_LSB-1:0] != '0);
endmodule

// File: rtl/vload_zext.sv
module vload_zext #(
  parameter int DATA_W = 128
) (
  input  logic [2:0]        scale_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int NB = DATA_W / 8;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign data_o[g*8 +: 8] = (g < (32'd1 << scale_i)) ? data_i[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/vload_unit.sv
module vload_unit
  import vload_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VREG_W    = 128,
  parameter int IDX_W     = 5,
  parameter int ALIGN_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_valid_i,
  input  logic [31:0]       insn_i,
  output logic              insn_ready_o,
  input  logic              fp_en_i,
  input  logic [1:0]        el_i,
  input  logic              sp_align_chk_i,
  output logic [IDX_W-1:0]  gpr_idx_o,
  input  logic [ADDR_W-1:0] gpr_data_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [2:0]        req_size_o,
  output logic              req_priv_o,
  output logic              req_tag_chk_o,
  output logic              req_nontemp_o,
  input  logic              rsp_valid_i,
  input  logic [VREG_W-1:0] rsp_data_i,
  output logic              vrf_we_o,
  output logic [IDX_W-1:0]  vrf_idx_o,
  output logic [VREG_W-1:0] vrf_data_o,
  output logic              undef_o,
  output logic              fp_trap_o,
  output logic              align_fault_o
);
  st_e               state_q;
  dec_t              dec;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              tag_d, tag_q, misalign;
  logic [2:0]        scale_q;
  logic              priv_q;
  logic [IDX_W-1:0]  rt_q;
  logic              accept, go;
  logic              undef_q, trap_q, align_q;

  vload_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  vload_agu #(.ADDR_W(ADDR_W), .IMM_W(9), .IDX_W(IDX_W), .ALIGN_LSB(ALIGN_LSB)) u_agu (
    .rn_i(dec.rn), .imm_i(dec.imm), .gpr_i(gpr_data_i), .sp_i(sp_i),
    .chk_en_i(sp_align_chk_i), .addr_o(addr_d), .tag_chk_o(tag_d), .misalign_o(misalign)
  );

  vload_zext #(.DATA_W(VREG_W)) u_zext (
    .scale_i(scale_q), .data_i(rsp_data_i), .data_o(vrf_data_o)
  );

  assign gpr_idx_o    = dec.rn;
  assign insn_ready_o = (state_q == ST_IDLE);
  assign accept       = insn_valid_i && insn_ready_o;
  // priority: undefined > fp disabled > sp alignment
  assign go           = accept && !dec.undef && fp_en_i && !misalign;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      scale_q <= '0;
      tag_q   <= 1'b0;
      priv_q  <= 1'b0;
      rt_q    <= '0;
      undef_q <= 1'b0;
      trap_q  <= 1'b0;
      align_q <= 1'b0;
    end else begin
      undef_q <= accept && dec.undef;
      trap_q  <= accept && !dec.undef && !fp_en_i;
      align_q <= accept && !dec.undef && fp_en_i && misalign;
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_REQ;
          addr_q  <= addr_d;
          scale_q <= dec.scale;
          tag_q   <= tag_d;
          priv_q  <= (el_i != 2'd0);
          rt_q    <= dec.rt;
        end
        ST_REQ:  if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o   = (state_q == ST_REQ);
  assign req_addr_o    = addr_q;
  assign req_size_o    = scale_q;
  assign req_priv_o    = priv_q;
  assign req_tag_chk_o = tag_q;
  assign req_nontemp_o = 1'b0;
  assign vrf_we_o      = (state_q == ST_WAIT) && rsp_valid_i;
  assign vrf_idx_o     = rt_q;
  assign undef_o       = undef_q;
  assign fp_trap_o     = trap_q;
  assign align_fault_o = align_q;

  p_one_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({undef_o, fp_trap_o, align_fault_o}));

  p_fault_no_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_o || fp_trap_o || align_fault_o) |-> !req_valid_o);

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_size_o)));

  p_req_after_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(insn_valid_i));

  p_no_accept_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vrf_we_o |-> !insn_ready_o);
endmodule

// File: tb/vload_unit_bench.sv
module vload_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0]  SP_BASE = 64'h0000_7FFF_FFF0_0000;
  localparam logic [127:0] RSP = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         insn_valid = 1'b0, insn_ready;
  logic [31:0]  insn = '0;
  logic         fp_en = 1'b1, align_chk = 1'b0;
  logic [1:0]   el = '0;
  logic [4:0]   gpr_idx;
  logic [63:0]  gpr_data, sp = SP_BASE;
  logic         req_valid, req_ready = 1'b0, req_priv, req_tag, req_nt;
  logic [63:0]  req_addr;
  logic [2:0]   req_size;
  logic         rsp_valid = 1'b0;
  logic [127:0] rsp_data = '0;
  logic         vrf_we;
  logic [4:0]   vrf_idx;
  logic [127:0] vrf_data;
  logic         undef_f, trap_f, align_f;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // register file model: value derived from index
  assign gpr_data = 64'h1000_0000_0000_0000 + {51'b0, gpr_idx, 8'h00};

  vload_unit u_vload_unit (
    .clk_i(clk), .rst_ni(rst_n), .insn_valid_i(insn_valid), .insn_i(insn),
    .insn_ready_o(insn_ready), .fp_en_i(fp_en), .el_i(el), .sp_align_chk_i(align_chk),
    .gpr_idx_o(gpr_idx), .gpr_data_i(gpr_data), .sp_i(sp),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .req_size_o(req_size), .req_priv_o(req_priv), .req_tag_chk_o(req_tag),
    .req_nontemp_o(req_nt), .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .vrf_we_o(vrf_we), .vrf_idx_o(vrf_idx), .vrf_data_o(vrf_data),
    .undef_o(undef_f), .fp_trap_o(trap_f), .align_fault_o(align_f)
  );

  typedef struct packed {
    logic [1:0] size;
    logic [1:0] opc;
    logic [8:0] imm;
    logic [4:0] rn;
    logic [4:0] rt;
    logic       fp;
    logic [1:0] el;
    logic       chk;
    logic [3:0] splow;
    logic [1:0] kind;   // 0 load, 1 undef, 2 trap, 3 align
    logic [2:0] esz;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'b01, 9'h005, 5'd3,  5'd1,  1'b1, 2'd0, 1'b1, 4'h0, 2'd0, 3'd0},
    '{2'd1, 2'b01, 9'h1FF, 5'd7,  5'd2,  1'b1, 2'd1, 1'b1, 4'h0, 2'd0, 3'd1},
    '{2'd2, 2'b01, 9'h100, 5'd0,  5'd9,  1'b1, 2'd2, 1'b0, 4'h0, 2'd0, 3'd2},
    '{2'd3, 2'b01, 9'h0FF, 5'd30, 5'd31, 1'b1, 2'd3, 1'b0, 4'h0, 2'd0, 3'd3},
    '{2'd0, 2'b11, 9'h010, 5'd31, 5'd4,  1'b1, 2'd1, 1'b1, 4'h0, 2'd0, 3'd4},
    '{2'd0, 2'b11, 9'h010, 5'd31, 5'd4,  1'b1, 2'd1, 1'b1, 4'h8, 2'd3, 3'd4},
    '{2'd3, 2'b01, 9'h1F0, 5'd31, 5'd5,  1'b1, 2'd0, 1'b0, 4'h8, 2'd0, 3'd3},
    '{2'd2, 2'b01, 9'h003, 5'd12, 5'd6,  1'b1, 2'd0, 1'b1, 4'h8, 2'd0, 3'd2},
    '{2'd1, 2'b11, 9'h000, 5'd1,  5'd0,  1'b1, 2'd0, 1'b0, 4'h0, 2'd1, 3'd0},
    '{2'd3, 2'b11, 9'h000, 5'd1,  5'd0,  1'b0, 2'd0, 1'b0, 4'h0, 2'd1, 3'd0},
    '{2'd2, 2'b01, 9'h000, 5'd2,  5'd0,  1'b0, 2'd0, 1'b0, 4'h0, 2'd2, 3'd0},
    '{2'd0, 2'b11, 9'h000, 5'd31, 5'd0,  1'b0, 2'd0, 1'b1, 4'h4, 2'd2, 3'd0},
    '{2'd2, 2'b00, 9'h000, 5'd2,  5'd0,  1'b1, 2'd0, 1'b0, 4'h0, 2'd1, 3'd0}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] s, input logic [1:0] o,
                                     input logic [8:0] i, input logic [4:0] n, input logic [4:0] t);
    return {s, 3'b111, 1'b1, 2'b00, o, 1'b0, i, 2'b00, n, t};
  endfunction

  function automatic logic [127:0] keep_bytes(input logic [127:0] d, input int nb);
    logic [127:0] r = '0;
    for (int b = 0; b < nb; b++) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  // present one word for one edge, then sample after it
  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    insn = w; insn_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  task automatic complete(input logic [4:0] rt, input int nb, input string tag);
    @(posedge clk);
    @(negedge clk);
    check({tag, " R11 held"}, {req_valid, insn_ready}, 2'b10);
    req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_ready = 1'b0;
    check({tag, " R11 handed off"}, {req_valid, insn_ready}, 2'b00);
    rsp_valid = 1'b1; rsp_data = RSP;
    #1;
    check({tag, " R10 we"}, vrf_we, 1'b1);
    check({tag, " R10 idx"}, vrf_idx, rt);
    check({tag, " R10 data"}, vrf_data, keep_bytes(RSP, nb));
    @(posedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
    check({tag, " R11 idle"}, {insn_ready, vrf_we}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset", {insn_ready, req_valid, vrf_we, undef_f, trap_f, align_f}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 after release", {insn_ready, req_valid, undef_f}, 3'b100);

    for (int k = 0; k < NV; k++) begin
      vec_t v = VEC[k];
      logic [63:0] base, eaddr;
      fp_en = v.fp; el = v.el; align_chk = v.chk; sp = SP_BASE | {60'b0, v.splow};
      base  = (v.rn == 5'd31) ? sp : 64'h1000_0000_0000_0000 + {51'b0, v.rn, 8'h00};
      eaddr = base + {{55{v.imm[8]}}, v.imm};
      issue(mk(v.size, v.opc, v.imm, v.rn, v.rt));
      if (v.kind == 2'd0) begin
        check($sformatf("R5 R4 addr v%0d", k), req_addr, eaddr);
        check($sformatf("R2 size v%0d", k), req_size, v.esz);
        check($sformatf("R6 tag v%0d", k), {req_tag, req_nt}, {v.rn != 5'd31, 1'b0});
        check($sformatf("R7 priv v%0d", k), req_priv, v.el != 2'd0);
        check($sformatf("R9 no fault v%0d", k), {req_valid, undef_f, trap_f, align_f}, 4'b1000);
        complete(v.rt, 1 << v.esz, $sformatf("v%0d", k));
      end else begin
        check($sformatf("R3 R8 R9 flags v%0d", k), {req_valid, undef_f, trap_f, align_f},
              {1'b0, v.kind == 2'd1, v.kind == 2'd2, v.kind == 2'd3});
        @(negedge clk);
        check($sformatf("R8 flag pulse v%0d", k), {req_valid, undef_f, trap_f, align_f, insn_ready}, 5'b00001);
      end
    end

    // R1: each fixed field broken on an otherwise legal 32-bit load
    fp_en = 1'b1; align_chk = 1'b0; el = 2'd0;
    for (int b = 0; b < 6; b++) begin
      logic [31:0] w = mk(2'd2, 2'b01, 9'h004, 5'd3, 5'd1);
      case (b)
        0: w[27] = 1'b0;
        1: w[26] = 1'b0;
        2: w[24] = 1'b1;
        3: w[21] = 1'b1;
        4: w[10] = 1'b1;
        default: w[22] = 1'b0;
      endcase
      issue(w);
      check($sformatf("R1 bad fixed bits case %0d", b), {req_valid, undef_f}, 2'b01);
    end

    // R11: new instruction ignored while busy
    issue(mk(2'd1, 2'b01, 9'h002, 5'd4, 5'd7));
    check("R5 gpr idx", gpr_idx, 5'd4);
    @(negedge clk);
    insn = mk(2'd3, 2'b01, 9'h000, 5'd8, 5'd9); insn_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
    check("R11 busy ignores word", {req_addr, req_size},
          {64'h1000_0000_0000_0402, 3'd1});
    complete(5'd7, 2, "busy");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule